// File: doc/BRIEF.md
# PCI Memory Target with Fault Injection

This block is a target-only agent for a 32-bit multiplexed PCI bus. It holds an internal word array behind one base address window. It claims memory reads and memory writes whose address falls inside that window. It claims configuration reads and writes when its select input is high during the address phase. It supports multi-phase bursts in both directions, masks writes byte by byte, and drives even parity one clock after each read data phase it sources.

To stress the master on the other side, the block can refuse a memory read with a retry, or end a burst early with a disconnect. Both are chosen pseudo-randomly from a free-running shift register. Each is scaled by an inverse-probability parameter, and a value of zero switches that fault off. The window size comes from a mask parameter. The low, fixed bits of the base register come from a flags parameter.

The bus is split into input and output halves with separate drive enables, so the block can sit beside other bus agents in a larger fabric.

Top module: `pcimt_target`

## Requirements
- R1: After the active-low reset, and whenever no access is claimed, ctl_oe, ad_oe and par_oe are low and devsel_n, trdy_n and stop_n are high.
- R2: Configuration accesses are claimed only when idsel is high in the address phase, the command is 1010 (read) or 1011 (write), and ad_in[1:0] is 00. The register index is address bits [7:2]. Index 0 reads the DEV_ID parameter, and writes to it change nothing. Indices other than 0, 1 and 4 read as zero.
- R3: Index 4 is the base register. Only the bits set in BAR_MASK are writable, and they reset to 0. The other bits read back from BAR_FLAGS.
- R4: Index 1 bit 1 is the memory-space enable (reset 0, byte lane 0). Its other bits read 0. A memory command (0110 read, 1100 read multiple, 1110 read line, 0111 write) is claimed only while that bit is set and ((address XOR base) AND BAR_MASK) is zero. An unclaimed access leaves every output idle.
- R5: The address phase is the first clock edge at which frame_n is low after being high. On a claimed access, ctl_oe rises after that edge with all strobes high. One clock later devsel_n falls, and trdy_n falls with it unless a retry was chosen. A data phase completes at an edge where irdy_n and trdy_n are both low.
- R6: Each completed data phase advances the address by 4 bytes. A phase that completes with frame_n high ends the access. It is followed by one cycle with ctl_oe high and all strobes high, and then the bus is released.
- R7: A write data phase updates only the byte lanes whose cbe_n bit is 0.
- R8: ad_oe is high in every read data phase that is not a retry. par_oe follows ad_oe one clock later. par_out then gives even parity over the previous cycle's ad_out and cbe_n.
- R9: For memory reads only, let r be the shift-register value at the address edge. A retry is chosen when RETRY_RATE is non-zero and r mod RETRY_RATE is 0. The first data phase then shows stop_n low with trdy_n high, and no data moves.
- R10: A disconnect is decided at each edge that starts a data phase (entry, or completion of the previous phase), using the register value r at that edge. It is chosen when DISCON_RATE is non-zero and r mod DISCON_RATE is 0. That phase shows stop_n and trdy_n low together and still transfers. If frame_n is still low after it, the block holds devsel_n and stop_n low with trdy_n high until frame_n rises.
- R11: The pseudo-random source is a 16-bit register. It resets to 16'hACE1. Every clock it shifts left, and the new bit 0 is bit15 ^ bit13 ^ bit12 ^ bit10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Access framing strobe from the master |
| irdy_n | input | 1 | Master ready strobe |
| idsel | input | 1 | Configuration select |
| ad_in | input | 32 | Address/data as seen on the bus |
| cbe_n | input | 4 | Command in the address phase, byte enables in data phases |
| ad_out | output | 32 | Read data driven onto the bus |
| ad_oe | output | 1 | Drive enable for ad_out |
| par_out | output | 1 | Even parity of the previous sourced phase |
| par_oe | output | 1 | Drive enable for par_out |
| devsel_n | output | 1 | Device select strobe |
| trdy_n | output | 1 | Target ready strobe |
| stop_n | output | 1 | Target stop strobe |
| ctl_oe | output | 1 | Drive enable for the three target strobes |

## Verification
Single-phase writes to each word, followed by burst reads of varying start and length, show whether the address advances per phase rather than per access. They also show whether a disconnect still moves its phase. Partial byte-enable writes with complementary lane patterns in consecutive phases show whether lanes are masked per phase. Configuration writes of all ones and of a sparse pattern to the base register separate writable bits from flag bits. Misses are tried with a disabled memory space, an address just outside the window, and a configuration read without select. Together they show that the decode depends on each of its inputs. The mix of the three read commands over many bursts checks the exact placement of retries and disconnects against the shift-register sequence.

// File: rtl/pcimt_pkg.sv
package pcimt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_DATA,
        ST_HOLD,
        ST_END
    } tgt_state_e;

    localparam logic [3:0] CMD_MRD  = 4'b0110;
    localparam logic [3:0] CMD_MWR  = 4'b0111;
    localparam logic [3:0] CMD_MRDM = 4'b1100;
    localparam logic [3:0] CMD_MRDL = 4'b1110;
    localparam logic [3:0] CMD_CRD  = 4'b1010;
    localparam logic [3:0] CMD_CWR  = 4'b1011;

    function automatic logic is_mem_read(input logic [3:0] c);
        return (c == CMD_MRD) || (c == CMD_MRDM) || (c == CMD_MRDL);
    endfunction

    function automatic logic is_cfg_cmd(input logic [3:0] c);
        return (c == CMD_CRD) || (c == CMD_CWR);
    endfunction

endpackage

// File: rtl/pcimt_lfsr.sv
module pcimt_lfsr #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [15:0] value
);
    logic [15:0] r_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= SEED;
        else        r_q <= {r_q[14:0], r_q[15] ^ r_q[13] ^ r_q[12] ^ r_q[10]};
    end

    assign value = r_q;
endmodule

// File: rtl/pcimt_inject.sv
module pcimt_inject #(
    parameter int unsigned RATE = 0
) (
    input  logic [15:0] rnd,
    output logic        fire
);
    generate
        if (RATE == 0) begin : g_off
            assign fire = 1'b0;
        end else begin : g_on
            assign fire = ((rnd % 16'(RATE)) == 16'd0);
        end
    endgenerate
endmodule

// File: rtl/pcimt_mem.sv
module pcimt_mem #(
    parameter int unsigned IW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [31:0]   wdata,
    input  logic [3:0]    be_n,
    output logic [31:0]   rdata
);
    localparam int unsigned WORDS = 1 << IW;

    logic [31:0] arr [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int b = 0; b < 4; b++) begin
                if (!be_n[b]) arr[idx][8*b +: 8] <= wdata[8*b +: 8];
            end
        end
    end

    assign rdata = arr[idx];
endmodule

// File: rtl/pcimt_target.sv
module pcimt_target
    import pcimt_pkg::*;
#(
    parameter logic [31:0] DEV_ID      = 32'h5A17_0C3E,
    parameter logic [31:0] BAR_MASK    = 32'hFFFF_F000,
    parameter logic [31:0] BAR_FLAGS   = 32'h0000_0008,
    parameter int unsigned RETRY_RATE  = 0,
    parameter int unsigned DISCON_RATE = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_n,
    input  logic        irdy_n,
    input  logic        idsel,
    input  logic [31:0] ad_in,
    input  logic [3:0]  cbe_n,
    output logic [31:0] ad_out,
    output logic        ad_oe,
    output logic        par_out,
    output logic        par_oe,
    output logic        devsel_n,
    output logic        trdy_n,
    output logic        stop_n,
    output logic        ctl_oe
);
    localparam int unsigned WIN_BYTES = int'((~BAR_MASK) + 32'd1);
    localparam int unsigned IW        = $clog2(WIN_BYTES / 4);

    typedef struct packed {
        tgt_state_e    st;
        logic [IW-1:0] widx;
        logic          rd;
        logic          cfg;
        logic          retry;
        logic          disc;
        logic          fprev;
        logic          memen;
        logic [31:0]   bar;
        logic          par;
        logic          paroe;
    } regs_t;

    regs_t q, d;

    logic [15:0] rnd;
    logic        retry_fire, disc_fire;
    logic        mem_we;
    logic [31:0] mem_rdata, cfg_rdata;
    logic        mem_hit, cfg_hit;

    pcimt_lfsr u_lfsr (.clk(clk), .rst_n(rst_n), .value(rnd));
    pcimt_inject #(.RATE(RETRY_RATE))  u_rty (.rnd(rnd), .fire(retry_fire));
    pcimt_inject #(.RATE(DISCON_RATE)) u_dsc (.rnd(rnd), .fire(disc_fire));

    pcimt_mem #(.IW(IW)) u_mem (
        .clk(clk), .we(mem_we), .idx(q.widx), .wdata(ad_in),
        .be_n(cbe_n), .rdata(mem_rdata)
    );

    always_comb begin
        unique case (q.widx[5:0])
            6'd0:    cfg_rdata = DEV_ID;
            6'd1:    cfg_rdata = {30'd0, q.memen, 1'b0};
            6'd4:    cfg_rdata = (q.bar & BAR_MASK) | (BAR_FLAGS & ~BAR_MASK);
            default: cfg_rdata = 32'd0;
        endcase
    end

    assign mem_hit = (is_mem_read(cbe_n) || cbe_n == CMD_MWR) && q.memen
                     && (((ad_in ^ q.bar) & BAR_MASK) == 32'd0);
    assign cfg_hit = is_cfg_cmd(cbe_n) && idsel && (ad_in[1:0] == 2'b00);

    assign ad_out   = q.cfg ? cfg_rdata : mem_rdata;
    assign ad_oe    = (q.st == ST_DATA) && q.rd && !q.retry;
    assign ctl_oe   = (q.st != ST_IDLE);
    assign devsel_n = !((q.st == ST_DATA) || (q.st == ST_HOLD));
    assign trdy_n   = !((q.st == ST_DATA) && !q.retry);
    assign stop_n   = !(((q.st == ST_DATA) && (q.retry || q.disc)) || (q.st == ST_HOLD));
    assign par_out  = q.par;
    assign par_oe   = q.paroe;

    always_comb begin
        logic [31:0] merged;
        d      = q;
        mem_we = 1'b0;
        merged = q.bar;
        d.fprev = frame_n;
        d.par   = ^{ad_out, cbe_n};
        d.paroe = ad_oe;
        unique case (q.st)
            ST_IDLE: begin
                if (!frame_n && q.fprev) begin
                    d.widx  = ad_in[IW+1:2];
                    d.rd    = is_mem_read(cbe_n) || (cbe_n == CMD_CRD);
                    d.cfg   = is_cfg_cmd(cbe_n);
                    d.retry = is_mem_read(cbe_n) && retry_fire;
                    d.disc  = 1'b0;
                    if (mem_hit || cfg_hit) d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                d.st   = ST_DATA;
                d.disc = !q.retry && disc_fire;
            end
            ST_DATA: begin
                if (!irdy_n) begin
                    if (q.retry) begin
                        d.st = frame_n ? ST_END : ST_HOLD;
                    end else begin
                        d.widx = q.widx + 1'b1;
                        if (!q.rd) begin
                            if (!q.cfg) begin
                                mem_we = 1'b1;
                            end else if (q.widx[5:0] == 6'd1) begin
                                if (!cbe_n[0]) d.memen = ad_in[1];
                            end else if (q.widx[5:0] == 6'd4) begin
                                for (int b = 0; b < 4; b++) begin
                                    if (!cbe_n[b]) merged[8*b +: 8] = ad_in[8*b +: 8];
                                end
                                d.bar = merged & BAR_MASK;
                            end
                        end
                        if (q.disc)       d.st = frame_n ? ST_END : ST_HOLD;
                        else if (frame_n) d.st = ST_END;
                        else              d.disc = disc_fire;
                    end
                end
            end
            ST_HOLD: if (frame_n) d.st = ST_END;
            ST_END:  d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.fprev <= 1'b1;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/pcimt_chk.sv
module pcimt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ctl_oe,
    input logic        devsel_n,
    input logic        trdy_n,
    input logic        stop_n,
    input logic        ad_oe,
    input logic [31:0] ad_out,
    input logic [3:0]  cbe_n,
    input logic        par_out,
    input logic        par_oe
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_oe |-> (devsel_n && trdy_n && stop_n && !ad_oe));

    // R5
    medium_devsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_oe) |-> devsel_n);

    // R5
    trdy_needs_devsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n |-> !devsel_n);

    // R10
    stop_needs_devsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_n |-> !devsel_n);

    // R8
    par_follows_ad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |=> par_oe);

    // R8
    par_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ad_oe |=> !par_oe);

    // R8
    par_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe |-> (par_out == ^{$past(ad_out), $past(cbe_n)}));
endmodule

bind pcimt_target pcimt_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_oe(ctl_oe), .devsel_n(devsel_n),
    .trdy_n(trdy_n), .stop_n(stop_n), .ad_oe(ad_oe), .ad_out(ad_out),
    .cbe_n(cbe_n), .par_out(par_out), .par_oe(par_oe)
);

// File: tb/sim_pcimt_target.sv
`timescale 1ns/1ps
module sim_pcimt_target;
    localparam logic [31:0] DEVID = 32'h5A17_0C3E;
    localparam logic [31:0] MASK  = 32'hFFFF_F000;
    localparam logic [31:0] FLAGS = 32'h0000_0008;
    localparam int RR = 3;
    localparam int DR = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0;
    logic [31:0] ad_in = '0;
    logic [3:0]  cbe_n = 4'hF;
    logic [31:0] ad_out;
    logic ad_oe, par_out, par_oe, devsel_n, trdy_n, stop_n, ctl_oe;

    always #4 clk = ~clk;

    pcimt_target #(.DEV_ID(DEVID), .BAR_MASK(MASK), .BAR_FLAGS(FLAGS),
                   .RETRY_RATE(RR), .DISCON_RATE(DR)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .idsel(idsel), .ad_in(ad_in), .cbe_n(cbe_n), .ad_out(ad_out),
        .ad_oe(ad_oe), .par_out(par_out), .par_oe(par_oe),
        .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n), .ctl_oe(ctl_oe));

    int n_cmp = 0, n_bad = 0;
    int n_retry = 0, n_disc = 0, n_burst = 0;
    bit done = 0;

    logic [15:0] m_lfsr;
    logic [31:0] m_mem [1024];
    logic        m_memen = 1'b0;
    logic [31:0] m_bar = '0;
    logic        prev_adoe = 1'b0;
    logic [31:0] prev_ad = '0;
    logic [3:0]  p_cbe = 4'hF;
    logic [31:0] wd [16];
    logic [3:0]  wb [16];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_lfsr <= 16'hACE1;
        else        m_lfsr <= {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    end

    always @(posedge clk) p_cbe <= cbe_n;

    task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] cfg_exp(input logic [5:0] idx);
        case (idx)
            6'd0:    return DEVID;
            6'd1:    return {30'd0, m_memen, 1'b0};
            6'd4:    return m_bar | (FLAGS & ~MASK);
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] rd_exp(input logic cfg, input logic [31:0] a);
        return cfg ? cfg_exp(a[7:2]) : m_mem[a[11:2]];
    endfunction

    task automatic model_write(input logic cfg, input logic [31:0] a, input logic [31:0] dt, input logic [3:0] be);
        logic [31:0] w;
        if (!cfg) begin
            w = m_mem[a[11:2]];
            for (int b = 0; b < 4; b++) if (!be[b]) w[8*b +: 8] = dt[8*b +: 8];
            m_mem[a[11:2]] = w;
        end else if (a[7:2] == 6'd1) begin
            if (!be[0]) m_memen = dt[1];
        end else if (a[7:2] == 6'd4) begin
            w = m_bar;
            for (int b = 0; b < 4; b++) if (!be[b]) w[8*b +: 8] = dt[8*b +: 8];
            m_bar = w & MASK;
        end
    endtask

    task automatic chk(input logic e_ctl, input logic e_dev, input logic e_trdy, input logic e_stop,
                       input logic e_adoe, input logic [31:0] e_ad, input string tag);
        cmp("ctl_oe", 32'(ctl_oe), 32'(e_ctl), tag);
        cmp("devsel_n", 32'(devsel_n), 32'(e_dev), tag);
        cmp("trdy_n", 32'(trdy_n), 32'(e_trdy), tag);
        cmp("stop_n", 32'(stop_n), 32'(e_stop), tag);
        cmp("ad_oe", 32'(ad_oe), 32'(e_adoe), tag);
        if (e_adoe) cmp("ad_out", ad_out, e_ad, tag);
        cmp("par_oe R8", 32'(par_oe), 32'(prev_adoe), tag);
        if (prev_adoe) cmp("par_out R8", 32'(par_out), 32'(^{prev_ad, p_cbe}), tag);
        prev_adoe = e_adoe;
        prev_ad   = e_ad;
    endtask

    task automatic idle(input int k, input string tag);
        for (int j = 0; j < k; j++) begin
            @(negedge clk);
            chk(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'd0, tag);
        end
    endtask

    task automatic xact(input logic [3:0] cmd, input logic [31:0] addr, input logic sel,
                        input int n, input string tag);
        logic is_rdm, is_mem, is_cfg, is_rd, hit, retry, disc, ended;
        logic [31:0] a, ev;
        logic [15:0] lf;
        int i;
        is_rdm = (cmd == 4'h6) || (cmd == 4'hC) || (cmd == 4'hE);
        is_mem = is_rdm || (cmd == 4'h7);
        is_cfg = (cmd == 4'hA) || (cmd == 4'hB);
        is_rd  = is_rdm || (cmd == 4'hA);
        hit = is_mem ? (m_memen && (((addr ^ m_bar) & MASK) == 32'd0))
                     : (is_cfg && sel && (addr[1:0] == 2'b00));
        @(negedge clk);
        chk(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'd0, tag);
        frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd; idsel = sel;
        lf = m_lfsr;
        retry = hit && is_rdm && ((lf % RR) == 0);
        @(negedge clk);
        chk(hit, 1'b1, 1'b1, 1'b1, 1'b0, 32'd0, tag);
        irdy_n = 1'b0; frame_n = (n == 1); idsel = 1'b0;
        ad_in = is_rd ? 32'd0 : wd[0]; cbe_n = wb[0];
        lf = m_lfsr;
        disc = !retry && ((lf % DR) == 0);
        if (!hit) begin
            @(negedge clk); chk(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'd0, tag);
            frame_n = 1'b1;
            @(negedge clk); chk(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'd0, tag);
            irdy_n = 1'b1; ad_in = '0;
            return;
        end
        a = addr; i = 0; ended = 1'b0;
        while (!ended) begin
            @(negedge clk);
            ev = is_rd ? rd_exp(is_cfg, a) : 32'd0;
            chk(1'b1, 1'b0, retry, !(retry || disc), is_rd && !retry, ev, tag);
            frame_n = (i == n - 1); irdy_n = 1'b0;
            ad_in = is_rd ? 32'd0 : wd[i]; cbe_n = wb[i];
            lf = m_lfsr;
            if (retry) begin
                ended = 1'b1; n_retry++;
            end else begin
                if (!is_rd) model_write(is_cfg, a, wd[i], wb[i]);
                a = a + 32'd4; i++;
                if (disc) begin ended = 1'b1; n_disc++; end
                else if (i == n) ended = 1'b1;
                else disc = ((lf % DR) == 0);
            end
        end
        if (is_rd && i >= 2) n_burst++;
        if (!frame_n) begin
            @(negedge clk);
            chk(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'd0, tag);
            frame_n = 1'b1; irdy_n = 1'b0;
        end
        @(negedge clk);
        chk(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 32'd0, tag);
        irdy_n = 1'b1; frame_n = 1'b1; ad_in = '0; cbe_n = 4'hF;
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        for (int k = 0; k < 16; k++) begin wd[k] = '0; wb[k] = 4'h0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(3, "R1");
        xact(4'h6, 32'h0000_0000, 1'b0, 1, "R4 disabled");
        xact(4'hA, 32'h0000_0000, 1'b0, 1, "R2 no select");
        xact(4'hA, 32'h0000_0001, 1'b1, 1, "R2 type bits");
        xact(4'hA, 32'h0000_0000, 1'b1, 3, "R2 read");
        wd[0] = 32'hFFFF_FFFF;
        xact(4'hB, 32'h0000_0000, 1'b1, 1, "R2 write ignored");
        xact(4'hA, 32'h0000_0000, 1'b1, 1, "R2 readback");
        xact(4'hB, 32'h0000_0010, 1'b1, 1, "R3 ones");
        xact(4'hA, 32'h0000_0010, 1'b1, 1, "R3 ones readback");
        wd[0] = 32'h0004_5ABC;
        xact(4'hB, 32'h0000_0010, 1'b1, 1, "R3 place");
        xact(4'hA, 32'h0000_0010, 1'b1, 1, "R3 place readback");
        wd[0] = 32'h0000_0002;
        xact(4'hB, 32'h0000_0004, 1'b1, 1, "R4 enable");
        xact(4'hA, 32'h0000_0004, 1'b1, 1, "R4 enable readback");
        for (int k = 0; k < 16; k++) begin
            wd[0] = (32'(k) * 32'h0101_0101) ^ 32'hA5A5_5A5A;
            xact(4'h7, 32'h0004_5000 + 32'(4 * k), 1'b0, 1, "R6 fill");
        end
        for (int k = 0; k < 6; k++) wd[k] = 32'hC0DE_0000 + 32'(k * 17);
        xact(4'h7, 32'h0004_5008, 1'b0, 6, "R6 burst write");
        xact(4'h6, 32'h0004_5004, 1'b0, 8, "R6 burst read");
        wd[0] = 32'h1122_3344; wb[0] = 4'b1010;
        wd[1] = 32'h5566_7788; wb[1] = 4'b0101;
        xact(4'h7, 32'h0004_5004, 1'b0, 2, "R7 lanes");
        wb[0] = 4'h0; wb[1] = 4'h0;
        xact(4'h6, 32'h0004_5004, 1'b0, 2, "R7 lanes readback");
        xact(4'h6, 32'h0004_6000, 1'b0, 2, "R4 above window");
        xact(4'h7, 32'h0004_4FFC, 1'b0, 1, "R4 below window");
        for (int k = 0; k < 30; k++) begin
            logic [3:0] c;
            c = (k % 3 == 0) ? 4'h6 : ((k % 3 == 1) ? 4'hC : 4'hE);
            xact(c, 32'h0004_5000 + 32'(4 * (k % 8)), 1'b0, 2 + (k % 7), "R9 R10 R11");
        end
        for (int k = 0; k < 10; k++) begin
            for (int j = 0; j < 4; j++) begin
                wd[j] = 32'h3C00_0000 ^ 32'(k * 256 + j);
                wb[j] = 4'(j * 3);
            end
            xact(4'h7, 32'h0004_5000 + 32'(4 * (k % 12)), 1'b0, 4, "R10 R7 writes");
        end
        for (int k = 0; k < 4; k++) wb[k] = 4'h0;
        xact(4'hE, 32'h0004_5000, 1'b0, 8, "R6 R8 final read");
        wd[0] = 32'h0;
        xact(4'hB, 32'h0000_0004, 1'b1, 1, "R4 disable");
        xact(4'h6, 32'h0004_5000, 1'b0, 1, "R4 disabled read");
        idle(2, "R1");
        cmp("retries seen", 32'(n_retry > 0), 32'd1, "R9");
        cmp("disconnects seen", 32'(n_disc > 0), 32'd1, "R10");
        cmp("multi-phase reads", 32'(n_burst > 0), 32'd1, "R6");
        summary();
    end
endmodule